// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast system clock into the sampling tick used by a UART transmitter and receiver. An optional divide-by-1 or divide-by-4 prescaler feeds a programmable divider. The divisor has a 16-bit integer part and a 4-bit fractional part in sixteenths. The fraction is produced by lengthening some tick periods by one prescaled clock. Those longer periods are spread as evenly as possible by a 4-bit phase accumulator.

The divisor is held in three byte-wide registers: two integer bytes and one fraction register. They can be read and written only while the divisor-latch-enable input is high. Any accepted write restarts the divider, so the new rate applies at once. Besides the sample tick, the block gives a bit-boundary strobe. This strobe fires once every 16, 8 or 4 ticks, according to the selected oversampling ratio.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the integer low byte reads 0x01, the integer high byte reads 0x00 and the fraction reads 0x00, so the divisor is exactly 1 and a tick is produced on every clock.
- R2: Register address 0 holds integer bits 7:0, address 1 holds integer bits 15:8, and address 2 holds the fraction in data bits 3:0. Bits 7:4 of the fraction always read 0.
- R3: While latch_en is 0, writes change no register and do not restart the divider, and reg_rdata reads 0.
- R4: With fraction 0 and the prescaler off, ticks are spaced exactly I clocks apart, where I is the integer part. An integer part of 0 behaves as 1.
- R5: Tick periods are numbered j = 0, 1, 2, ... from a restart. Period 0 lasts I prescaled clocks. Period j>=1 lasts I + floor(j*F/16) - floor((j-1)*F/16), so each run of 16 periods after the first holds exactly F lengthened periods.
- R6: With presc_sel = 1, the divider advances only on every 4th clock. The prescale phase restarts with the divider, so the first tick after a restart comes 4*I clocks later.
- R7: An accepted write restarts the divider, the fraction phase and the tick counter. The first tick then appears in the I-th prescaled clock after the write edge.
- R8: The oversampling ratio is 16 when both mode inputs are 0, 8 when mode8x is 1 (also when mode4x is 1 too), and 4 when only mode4x is 1.
- R9: bit_strobe is high only together with tick. It is high on tick number k after a restart (counting from 1) exactly when k is a multiple of the oversampling ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 integer low, 1 integer high, 2 fraction) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, 0 unless latch_en is high |
| latch_en | input | 1 | Divisor-latch-enable: opens register access |
| presc_sel | input | 1 | 1 selects divide-by-4 prescaling, 0 divide-by-1 |
| mode8x | input | 1 | Selects 8x oversampling (has priority) |
| mode4x | input | 1 | Selects 4x oversampling |
| tick | output | 1 | One-clock sampling tick |
| bit_strobe | output | 1 | One-clock strobe at each bit boundary |

## Verification
A wrong count or accumulator value shows up at the tick output within one tick period. The bench restarts the divider with a write and then compares every clock against the computed tick positions, so even a single misplaced extra cycle is caught in the first 16 periods. A wrong prescale phase moves the first tick away from cycle 4*I. A wrong tick counter or ratio moves the first strobe off tick 4, 8 or 16. Faulty access gating shows directly on reg_rdata, or as an unexpected restart of the tick pattern.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    OS_16 = 2'd0,
    OS_8  = 2'd1,
    OS_4  = 2'd2
  } os_mode_e;

  localparam int OS_CNT_W = 4;

  function automatic logic [OS_CNT_W-1:0] os_mask(input os_mode_e m);
    case (m)
      OS_8:    os_mask = OS_CNT_W'(7);
      OS_4:    os_mask = OS_CNT_W'(3);
      default: os_mask = OS_CNT_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
  parameter int DATA_W = 8,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              latch_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [INT_W-1:0]  div_int_o,
  output logic [INT_W-1:0]  div_int_nxt_o,
  output logic [FRAC_W-1:0] div_frac_o,
  output logic              restart_o
);
  localparam int NBYTES    = INT_W / DATA_W;
  localparam int FRAC_ADDR = NBYTES;

  logic [INT_W-1:0]  int_q, int_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              wr_ok;

  assign wr_ok = wr_i & latch_en_i;

  always_comb begin
    int_d  = int_q;
    frac_d = frac_q;
    if (wr_ok) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (addr_i == ADDR_W'(b)) int_d[b*DATA_W +: DATA_W] = wdata_i;
      end
      if (addr_i == ADDR_W'(FRAC_ADDR)) frac_d = wdata_i[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_W'(1);
      frac_q <= '0;
    end else if (wr_ok) begin
      int_q  <= int_d;
      frac_q <= frac_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (latch_en_i) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (addr_i == ADDR_W'(b)) rdata_o = int_q[b*DATA_W +: DATA_W];
      end
      if (addr_i == ADDR_W'(FRAC_ADDR)) rdata_o = DATA_W'(frac_q);
    end
  end

  assign div_int_o     = int_q;
  assign div_int_nxt_o = int_d;
  assign div_frac_o    = frac_q;
  assign restart_o     = wr_ok;

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRESC_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic restart_i,
  output logic pre_en_o
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_en;

  assign pcnt_en  = restart_i | sel_i;
  assign pre_en_o = sel_i ? (pcnt_q == LAST) : 1'b1;

  always_comb begin
    if (restart_i || pcnt_q == LAST) pcnt_d = '0;
    else                             pcnt_d = pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_en_i,
  input  logic              restart_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [INT_W-1:0]  div_int_nxt_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              tick_o
);
  logic [INT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   phase_sum;
  logic [INT_W-1:0]  int_eff, int_eff_nxt;
  logic              cnt_en;

  assign int_eff     = (div_int_i == '0)     ? INT_W'(1) : div_int_i;
  assign int_eff_nxt = (div_int_nxt_i == '0) ? INT_W'(1) : div_int_nxt_i;
  assign phase_sum   = {1'b0, acc_q} + {1'b0, div_frac_i};
  assign tick_o      = pre_en_i & (cnt_q == '0);
  assign cnt_en      = restart_i | pre_en_i;

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (restart_i) begin
      cnt_d = int_eff_nxt - INT_W'(1);
      acc_d = '0;
    end else if (tick_o) begin
      cnt_d = int_eff - INT_W'(1) + INT_W'(phase_sum[FRAC_W]);
      acc_d = phase_sum[FRAC_W-1:0];
    end else if (pre_en_i) begin
      cnt_d = cnt_q - INT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/baud_strobe.sv
module baud_strobe
  import baud_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     restart_i,
  input  os_mode_e mode_i,
  output logic     strobe_o
);
  logic [OS_CNT_W-1:0] tcnt_q, tcnt_d;
  logic [OS_CNT_W-1:0] mask;
  logic                tcnt_en;

  assign mask     = os_mask(mode_i);
  assign strobe_o = tick_i & ((tcnt_q & mask) == mask);
  assign tcnt_en  = restart_i | tick_i;

  always_comb begin
    if (restart_i) tcnt_d = '0;
    else           tcnt_d = tcnt_q + OS_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tcnt_q <= '0;
    else if (tcnt_en) tcnt_q <= tcnt_d;
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int INT_W     = 16,
  parameter int FRAC_W    = 4,
  parameter int PRESC_DIV = 4,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              latch_en,
  input  logic              presc_sel,
  input  logic              mode8x,
  input  logic              mode4x,
  output logic              tick,
  output logic              bit_strobe
);
  logic [INT_W-1:0]  div_int, div_int_nxt;
  logic [FRAC_W-1:0] div_frac;
  logic              restart;
  logic              pre_en;
  os_mode_e          os_sel;

  assign os_sel = mode8x ? OS_8 : (mode4x ? OS_4 : OS_16);

  baud_regs #(.DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .latch_en_i(latch_en), .rdata_o(reg_rdata), .div_int_o(div_int),
    .div_int_nxt_o(div_int_nxt), .div_frac_o(div_frac), .restart_o(restart)
  );

  baud_prescale #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel_i(presc_sel), .restart_i(restart), .pre_en_o(pre_en)
  );

  baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .pre_en_i(pre_en), .restart_i(restart),
    .div_int_i(div_int), .div_int_nxt_i(div_int_nxt), .div_frac_i(div_frac), .tick_o(tick)
  );

  baud_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(restart),
    .mode_i(os_sel), .strobe_o(bit_strobe)
  );

endmodule

// File: rtl/baud_checker.sv
module baud_checker #(
  parameter int DATA_W = 8,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              latch_en,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              presc_sel,
  input logic              tick,
  input logic              bit_strobe,
  input logic [INT_W-1:0]  div_int,
  input logic [FRAC_W-1:0] div_frac
);

  assert_locked_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !latch_en) |=> ($stable(div_int) && $stable(div_frac)));

  assert_read_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |-> (reg_rdata == '0));

  assert_min_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !presc_sel && div_int > INT_W'(1) && !(reg_wr && latch_en)) |=> !tick);

  assert_presc_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc_sel) |=> (!tick || !presc_sel));

  assert_restart_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && latch_en) |=> !bit_strobe);

  assert_strobe_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> tick);

endmodule

bind frac_baud_gen baud_checker #(.DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .latch_en(latch_en), .reg_rdata(reg_rdata),
  .presc_sel(presc_sel), .tick(tick), .bit_strobe(bit_strobe),
  .div_int(div_int), .div_frac(div_frac)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       latch_en;
  logic       presc_sel;
  logic       mode8x;
  logic       mode4x;
  logic       tick;
  logic       bit_strobe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .latch_en(latch_en), .presc_sel(presc_sel), .mode8x(mode8x),
    .mode4x(mode4x), .tick(tick), .bit_strobe(bit_strobe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 check(reg_rdata == exp[7:0], req, reg_rdata, exp);
  endtask

  task automatic program_div(input int ival, input int f);
    wr_reg(2'd0, ival[7:0]);
    wr_reg(2'd1, ival[15:8]);
    wr_reg(2'd2, f[7:0]);
  endtask

  // Follows the last restart; compares every clock against computed tick/strobe positions.
  task automatic measure(input int n, input int pdiv, input int ival, input int f,
                         input int ratio, input string req);
    int pos[64];
    int ie;
    int sum;
    int k;
    int bad_t;
    int bad_s;
    bit exp_t;
    bit exp_s;
    ie = (ival == 0) ? 1 : ival;
    sum = 0; k = 0; bad_t = 0; bad_s = 0;
    for (int j = 0; j < n; j++) begin
      int ext;
      ext = (j == 0) ? 0 : ((j * f) / 16 - ((j - 1) * f) / 16);
      sum += (ie + ext) * pdiv;
      pos[j] = sum;
    end
    for (int c = 1; c <= pos[n-1]; c++) begin
      @(negedge clk);
      exp_t = (k < n) && (c == pos[k]);
      exp_s = exp_t && (((k + 1) % ratio) == 0);
      if (tick !== exp_t) begin
        if (bad_t == 0) $display("  first tick mismatch at cycle %0d", c);
        bad_t++;
      end
      if (bit_strobe !== exp_s) bad_s++;
      if (exp_t) k++;
    end
    check(bad_t == 0, {req, " tick positions"}, bad_t, 0);
    check(bad_s == 0, {req, " strobe positions"}, bad_s, 0);
  endtask

  task automatic t_reset();
    int hits;
    rd_check(2'd0, 8'h01, "R1 low byte");
    rd_check(2'd1, 8'h00, "R1 high byte");
    rd_check(2'd2, 8'h00, "R1 fraction");
    hits = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (tick === 1'b1) hits++;
    end
    check(hits == 8, "R1 tick every clock", hits, 8);
  endtask

  task automatic t_gate();
    latch_en = 1'b0;
    wr_reg(2'd0, 8'h55);
    wr_reg(2'd2, 8'h07);
    rd_check(2'd0, 8'h00, "R3 read blocked");
    latch_en = 1'b1;
    rd_check(2'd0, 8'h01, "R3 low byte kept");
    rd_check(2'd2, 8'h00, "R3 fraction kept");
  endtask

  task automatic t_map();
    wr_reg(2'd2, 8'hFF);
    rd_check(2'd2, 8'h0F, "R2 fraction width");
    wr_reg(2'd0, 8'h02);
    wr_reg(2'd1, 8'h01);
    rd_check(2'd0, 8'h02, "R2 low byte");
    rd_check(2'd1, 8'h01, "R2 high byte");
    program_div(258, 0);
    measure(3, 1, 258, 0, 16, "R2 wide integer");
  endtask

  task automatic t_integer();
    program_div(10, 0);
    measure(40, 1, 10, 0, 16, "R4 R7 integer 10");
    program_div(0, 0);
    measure(20, 1, 0, 0, 16, "R4 zero as one");
  endtask

  task automatic t_fraction();
    program_div(3, 5);
    measure(40, 1, 3, 5, 16, "R5 3+5/16");
    program_div(1, 15);
    measure(40, 1, 1, 15, 16, "R5 1+15/16");
    program_div(2, 8);
    measure(34, 1, 2, 8, 16, "R5 2+8/16");
  endtask

  task automatic t_presc();
    presc_sel = 1'b1;
    program_div(3, 0);
    measure(20, 4, 3, 0, 16, "R6 prescale integer");
    program_div(2, 3);
    measure(20, 4, 2, 3, 16, "R6 prescale fraction");
    presc_sel = 1'b0;
  endtask

  task automatic t_modes();
    mode8x = 1'b1; mode4x = 1'b0;
    program_div(2, 0);
    measure(24, 1, 2, 0, 8, "R8 R9 ratio 8");
    mode8x = 1'b0; mode4x = 1'b1;
    program_div(2, 1);
    measure(24, 1, 2, 1, 4, "R8 R9 ratio 4");
    mode8x = 1'b1; mode4x = 1'b1;
    program_div(1, 0);
    measure(24, 1, 1, 0, 8, "R8 priority 8x");
    mode8x = 1'b0; mode4x = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    latch_en = 1'b1; presc_sel = 1'b0; mode8x = 1'b0; mode4x = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_gate();
    t_map();
    t_integer();
    t_fraction();
    t_presc();
    t_modes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule